// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial front end of a 1024-byte memory. It is an SPI slave that works in clock modes 0 and 3. It takes an 8-bit command and then a 16-bit address, most significant bit first. For reads it streams bytes out from the array and steps the address after each byte. For writes it collects up to one page of data in a staging buffer, then copies that page into the array during a timed busy period that starts when chip select is released. The array is plain on-chip RAM inside the block.

The serial pins are brought into a single system clock through two-flop synchronisers and edge detectors, so every serial edge becomes a one-cycle pulse. A separate protection unit sits outside the block and answers three questions:
- whether writes are currently enabled;
- whether the page being committed is locked, based on an address the block presents;
- what value the status byte should have.

The block reports its busy state back to that unit. Command codes that this block does not handle fall silent until the next deselect.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset `so_oe` and `busy` are 0, and no command is decoded until `cs_n` has been seen high and then low; a `cs_n` held low through reset selects nothing and `so_oe` stays 0.
- R2: SI is sampled on SCK rising edges and SO changes only after SCK falling edges; `so_oe` is 1 from a `cs_n` fall until the next `cs_n` rise and 0 afterwards.
- R3: Command 0x03 followed by a 16-bit address returns, MSB first, the byte stored at the address's low 10 bits. The upper 6 address bits have no effect.
- R4: A read keeps streaming one byte per 8 clocks at the next higher address, and rolls over from 0x3FF to 0x000.
- R5: Command 0x02, an address and one or more whole data bytes, followed by a `cs_n` rise exactly on a byte boundary, commits the bytes to the array.
- R6: Write data fills the page (PAGE bytes, aligned to PAGE) at the address's offset, and wraps to offset 0 of the same page. A later byte at a reused offset replaces the earlier one, and other pages are untouched.
- R7: A `cs_n` rise in the middle of a data byte, or before any data byte, aborts the write: the array is unchanged and `busy` stays 0.
- R8: A commit happens only if `wr_allow` is 1 and `addr_locked` is 0 at the `cs_n` rise. `lock_addr` presents the page base address during the check. Otherwise the array is unchanged and `busy` stays 0.
- R9: A commit raises `busy` for exactly WRITE_CYCLES system clocks. Selecting and deselecting the device during that time does not shorten it.
- R10: While `busy` is 1, commands 0x03 and 0x02 are ignored: SO stays 0 for the rest of that selection and the array is not changed.
- R11: Command 0x05 returns `{status_in[7:1], busy}` in every following byte until deselect, including while `busy` is 1.
- R12: Any other command code makes the rest of the selection silent (SO stays 0). The next selection decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad driver |
| wr_allow | input | 1 | Write-enable state from the protection unit |
| lock_addr | output | 10 | Base address of the page being written, for the protection query |
| addr_locked | input | 1 | Protection answer for `lock_addr` |
| status_in | input | 8 | Status byte from the protection unit; bit 0 is replaced by `busy` |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two things can coincide. One is a chip-select release that also completes a byte: it both ends the serial transfer and decides whether a commit starts. The other is a new selection arriving while an earlier commit is still running. The bench provokes the first by releasing `cs_n` right after the last data bit, after four bits of a byte, and after the address alone, and judges the outcome by the busy pulse and by the bytes read back. It provokes the second by issuing a status read, an array read and a write during the busy window. The status must show busy, the read must return zeros, and after the window closes the array must hold only the earlier commit.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_READ,
    PH_WRITE,
    PH_STAT,
    PH_MUTE
  } phase_t;

  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam logic [7:0] CMD_STAT  = 8'h05;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic sel_on,
  output logic sel_off,
  output logic sck_up,
  output logic sck_dn,
  output logic si_s
);
  localparam int HW = STAGES + 1;

  logic [HW-1:0]     cs_p;
  logic [HW-1:0]     sck_p;
  logic [STAGES-1:0] si_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p  <= '0;
      sck_p <= '0;
      si_p  <= '0;
    end else begin
      cs_p  <= {cs_p[HW-2:0], cs_n};
      sck_p <= {sck_p[HW-2:0], sck};
      si_p  <= {si_p[STAGES-2:0], si};
    end
  end

  assign sel_on  =  cs_p[HW-1] & ~cs_p[HW-2];
  assign sel_off = ~cs_p[HW-1] &  cs_p[HW-2];
  assign sck_up  = ~sck_p[HW-1] &  sck_p[HW-2];
  assign sck_dn  =  sck_p[HW-1] & ~sck_p[HW-2];
  assign si_s    =  si_p[STAGES-1];

endmodule

// File: rtl/spi_page_buf.sv
module spi_page_buf #(
  parameter int PAGE = 16,
  parameter int DW   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    we,
  input  logic [$clog2(PAGE)-1:0] widx,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(PAGE)-1:0] ridx,
  output logic [DW-1:0]           rdata,
  output logic                    rvalid
);
  logic [DW-1:0] slot [PAGE];
  logic [PAGE-1:0] filled;

  always_ff @(posedge clk) begin
    if (we) slot[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) filled <= '0;
    else if (we)    filled[widx] <= 1'b1;
  end

  assign rdata  = slot[ridx];
  assign rvalid = filled[ridx];

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 10,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int PAGE         = 16,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              wr_allow,
  output logic [ADDR_W-1:0] lock_addr,
  input  logic              addr_locked,
  input  logic [7:0]        status_in,
  output logic              busy
);
  localparam int PAGE_W = $clog2(PAGE);
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic sel_on, sel_off, sck_up, sck_dn, si_s;

  spi_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .sel_on(sel_on), .sel_off(sel_off), .sck_up(sck_up), .sck_dn(sck_dn), .si_s(si_s)
  );

  phase_t            phase;
  logic [2:0]        bit_cnt;
  logic [7:0]        sh_in;
  logic              addr_lo;
  logic              is_read;
  logic [ADDR_W-1:0] cur_addr;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] wr_idx;
  logic              got_byte;
  logic [7:0]        out_sh;
  logic [2:0]        out_cnt;
  logic [1:0]        ld_p;
  logic              so_q, oe_q;
  logic              busy_q, run_q;
  logic [CNT_W-1:0]  busy_cnt;
  logic [PAGE_W-1:0] cidx;

  logic [7:0]        byte_in;
  logic [ADDR_W-1:0] addr_nxt;
  logic              byte_end, buf_we, buf_clr, buf_valid, ram_we, commit;
  logic [7:0]        buf_rdata, ram_rdata;

  assign byte_in  = {sh_in[6:0], si_s};
  assign addr_nxt = {cur_addr[ADDR_W-2:0], si_s};
  assign byte_end = sck_up && (bit_cnt == 3'd7);
  assign buf_we   = byte_end && (phase == PH_WRITE);
  assign buf_clr  = byte_end && (phase == PH_ADDR) && addr_lo && !is_read;
  assign commit   = sel_off && (phase == PH_WRITE) && (bit_cnt == 3'd0) && got_byte
                    && wr_allow && !addr_locked && !busy_q;
  assign ram_we   = run_q && buf_valid;

  spi_page_buf #(.PAGE(PAGE), .DW(8)) u_pbuf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .widx(wr_idx),
    .wdata(byte_in), .ridx(cidx), .rdata(buf_rdata), .rvalid(buf_valid)
  );

  spi_mem_array #(.ADDR_W(ADDR_W), .DW(8)) u_array (
    .clk(clk), .we(ram_we), .waddr({page_q, cidx}), .wdata(buf_rdata),
    .raddr(cur_addr), .rdata(ram_rdata)
  );

  // Serial command engine
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      sh_in    <= '0;
      addr_lo  <= 1'b0;
      is_read  <= 1'b0;
      cur_addr <= '0;
      page_q   <= '0;
      wr_idx   <= '0;
      got_byte <= 1'b0;
      out_sh   <= '0;
      out_cnt  <= '0;
      ld_p     <= '0;
      so_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      ld_p <= {ld_p[0], 1'b0};
      if (sel_off) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else if (sel_on) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        addr_lo <= 1'b0;
        so_q    <= 1'b0;
        oe_q    <= 1'b1;
      end else begin
        if (sck_up && phase != PH_IDLE && phase != PH_MUTE) begin
          bit_cnt <= bit_cnt + 3'd1;
          sh_in   <= byte_in;
          unique case (phase)
            PH_CMD: if (bit_cnt == 3'd7) begin
              out_cnt <= '0;
              if ((byte_in == CMD_READ || byte_in == CMD_WRITE) && !busy_q) begin
                phase   <= PH_ADDR;
                is_read <= (byte_in == CMD_READ);
              end else if (byte_in == CMD_STAT) begin
                phase  <= PH_STAT;
                out_sh <= {status_in[7:1], busy_q};
              end else begin
                phase <= PH_MUTE;
              end
            end
            PH_ADDR: begin
              cur_addr <= addr_nxt;
              if (bit_cnt == 3'd7) begin
                addr_lo <= 1'b1;
                if (addr_lo && is_read) begin
                  phase   <= PH_READ;
                  ld_p[0] <= 1'b1;
                end else if (addr_lo) begin
                  phase    <= PH_WRITE;
                  page_q   <= addr_nxt[ADDR_W-1:PAGE_W];
                  wr_idx   <= addr_nxt[PAGE_W-1:0];
                  got_byte <= 1'b0;
                end
              end
            end
            PH_WRITE: if (bit_cnt == 3'd7) begin
              wr_idx   <= wr_idx + 1'b1;
              got_byte <= 1'b1;
            end
            default: ;
          endcase
        end
        if (sck_dn && (phase == PH_READ || phase == PH_STAT)) begin
          so_q    <= out_sh[7];
          out_sh  <= {out_sh[6:0], 1'b0};
          out_cnt <= out_cnt + 3'd1;
          if (out_cnt == 3'd7) begin
            if (phase == PH_READ) begin
              cur_addr <= cur_addr + 1'b1;
              ld_p[0]  <= 1'b1;
            end else begin
              out_sh <= {status_in[7:1], busy_q};
            end
          end
        end
        if (ld_p[1]) out_sh <= ram_rdata;
      end
    end
  end

  // Timed commit of the page buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      run_q    <= 1'b0;
      busy_cnt <= '0;
      cidx     <= '0;
    end else if (commit) begin
      busy_q   <= 1'b1;
      run_q    <= 1'b1;
      busy_cnt <= CNT_W'(WRITE_CYCLES - 1);
      cidx     <= '0;
    end else begin
      if (busy_q) begin
        if (busy_cnt == '0) busy_q <= 1'b0;
        else                busy_cnt <= busy_cnt - 1'b1;
      end
      if (run_q) begin
        cidx <= cidx + 1'b1;
        if (cidx == PAGE_W'(PAGE - 1)) run_q <= 1'b0;
      end
    end
  end

  assign so        = so_q;
  assign so_oe     = oe_q;
  assign busy      = busy_q;
  assign lock_addr = {page_q, {PAGE_W{1'b0}}};

  // R9
  commit_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(sel_off));

  // R2
  oe_off_after_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    sel_off |=> !oe_q);

  // R7
  no_commit_midbyte_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_off && phase == PH_WRITE && bit_cnt != 3'd0 && !busy_q) |=> !busy_q);

  // R10
  array_write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy_q);

  // R12
  mute_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MUTE) |-> !so_q);

endmodule

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;
  localparam int ADDR_W = 10;
  localparam int PAGE   = 16;
  localparam int WCYC   = 2000;
  localparam int H      = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe, busy;
  logic wr_allow = 1'b1;
  logic lock_upper = 1'b0;
  logic [ADDR_W-1:0] lock_addr;
  logic addr_locked;
  logic [7:0] status_in = 8'h8A;

  int n_chk = 0, n_err = 0;
  int busy_run = 0, busy_len = 0;
  int oe_seen = 0;
  logic [7:0] model [1024];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];

  always #2.5 clk = ~clk;

  assign addr_locked = lock_upper && (lock_addr[9:8] == 2'b11);

  spi_mem_slave #(.ADDR_W(ADDR_W), .PAGE(PAGE), .WRITE_CYCLES(WCYC)) u_spi_mem_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe),
    .wr_allow(wr_allow), .lock_addr(lock_addr), .addr_locked(addr_locked),
    .status_in(status_in), .busy(busy)
  );

  always @(negedge clk) begin
    if (busy) busy_run++;
    else if (busy_run != 0) begin busy_len = busy_run; busy_run = 0; end
    if (so_oe) oe_seen++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      si = d[i];
      repeat (H) @(negedge clk);
      q[i] = so;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (H + 4) @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic [7:0] q;
    sel();
    xfer(8'h03, q); xfer(a[15:8], q); xfer(a[7:0], q);
    for (int i = 0; i < n; i++) begin xfer(8'h00, q); rbuf[i] = q; end
    desel();
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    logic [7:0] q;
    sel();
    xfer(8'h02, q); xfer(a[15:8], q); xfer(a[7:0], q);
    for (int i = 0; i < n; i++) xfer(wbuf[i], q);
    desel();
  endtask

  task automatic model_write(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++)
      model[{a[9:4], 4'(a[3:0] + 4'(i))}] = wbuf[i];
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_read(input string req, input logic [15:0] a, input int n);
    do_read(a, n);
    for (int i = 0; i < n; i++)
      chk(req, rbuf[i], model[10'(a[9:0] + 10'(i))]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    for (int i = 0; i < 1024; i++) model[i] = 8'h00;

    // R1: chip select held low through reset must not select the device
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset so_oe", so_oe, 0);
    chk("R1 reset busy", busy, 0);
    oe_seen = 0;
    xfer(8'h05, q); xfer(8'h00, q);
    chk("R1 no select without cs fall", oe_seen, 0);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);

    // R5 R9 R2: basic write commit and busy length
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hC1 + 8'(i);
    busy_len = 0;
    oe_seen = 0;
    do_write(16'h0123, 4);
    chk("R2 so_oe while selected", int'(oe_seen > 0), 1);
    chk("R2 so_oe off after deselect", so_oe, 0);
    chk("R5 busy after commit", busy, 1);
    model_write(16'h0123, 4);

    // R11 status during busy
    sel(); xfer(8'h05, q); xfer(8'h00, q);
    chk("R11 status busy byte0", q, 8'h8B);
    xfer(8'h00, q);
    chk("R11 status busy byte1", q, 8'h8B);
    desel();
    // R10 read and write during busy are ignored
    do_read(16'h0123, 2);
    chk("R10 read in busy byte0", rbuf[0], 0);
    chk("R10 read in busy byte1", rbuf[1], 0);
    for (int i = 0; i < 2; i++) wbuf[i] = 8'h5A;
    do_write(16'h0123, 2);
    chk("R9 still busy after reselect", busy, 1);
    wait_idle();
    chk("R9 busy length", busy_len, WCYC);
    sel(); xfer(8'h05, q); xfer(8'h00, q); desel();
    chk("R11 status idle", q, 8'h8A);
    check_read("R5 R10 readback", 16'h0123, 4);

    // R3 upper address bits ignored
    check_read("R3 upper bits ignored", 16'hFC24, 2);

    // R6 wrap inside page
    for (int i = 0; i < PAGE + 3; i++) wbuf[i] = 8'h20 + 8'(i);
    do_write(16'h004E, PAGE + 3);
    model_write(16'h004E, PAGE + 3);
    wait_idle();
    check_read("R6 page wrap", 16'h0040, PAGE + 2);

    // R4 rollover
    for (int i = 0; i < 2; i++) wbuf[i] = 8'h9E + 8'(i);
    do_write(16'h03FE, 2);
    model_write(16'h03FE, 2);
    wait_idle();
    wbuf[0] = 8'h77;
    do_write(16'h0000, 1);
    model_write(16'h0000, 1);
    wait_idle();
    check_read("R4 rollover", 16'h03FE, 4);

    // R7 aborts: mid-byte and address only
    sel(); xfer(8'h02, q); xfer(8'h00, q); xfer(8'h80, q);
    for (int i = 0; i < 4; i++) begin
      si = 1'b1; repeat (H) @(negedge clk); sck = 1'b1; repeat (H) @(negedge clk); sck = 1'b0;
    end
    desel();
    chk("R7 midbyte no busy", busy, 0);
    sel(); xfer(8'h02, q); xfer(8'h00, q); xfer(8'h81, q); desel();
    chk("R7 no data no busy", busy, 0);
    check_read("R7 array unchanged", 16'h0080, 2);

    // R8 protection hooks
    wr_allow = 1'b0;
    wbuf[0] = 8'hEE;
    do_write(16'h0090, 1);
    chk("R8 disabled no busy", busy, 0);
    wr_allow = 1'b1;
    lock_upper = 1'b1;
    do_write(16'h0310, 1);
    chk("R8 locked no busy", busy, 0);
    chk("R8 lock_addr page base", lock_addr, 10'h310);
    do_write(16'h0210, 1);
    chk("R8 unlocked commits", busy, 1);
    model_write(16'h0210, 1);
    wait_idle();
    lock_upper = 1'b0;
    check_read("R8 disabled unchanged", 16'h0090, 1);
    check_read("R8 locked unchanged", 16'h0310, 1);
    check_read("R8 unlocked written", 16'h0210, 1);

    // R12 unknown command mutes the selection
    sel(); xfer(8'hA5, q); xfer(8'h00, q); xfer(8'h00, q); desel();
    chk("R12 unknown silent", q, 0);
    sel(); xfer(8'h06, q); xfer(8'h00, q); desel();
    chk("R12 unhandled code silent", q, 0);
    check_read("R12 next selection decodes", 16'h0123, 1);

    // R5 R6 R3 random writes and reads
    for (int k = 0; k < 6; k++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom_range(0, 767)) | (16'($urandom_range(0, 63)) << 10);
      n = $urandom_range(1, PAGE + 3);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n);
      model_write(a, n);
      wait_idle();
      check_read("R5 R6 random", {6'h00, a[9:4], 4'h0}, PAGE);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule